// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers a large set of level-sensitive interrupt requests and presents the most urgent one to a single processor core. The first `NUM_SW` sources are driven by software through register writes. The remaining sources come from hardware request lines. Each source carries a 4-bit priority that software can program. Its vector number is fixed and equals its source index.

The controller compares the best pending request against a current-priority level. If the request is strictly higher, it raises a registered interrupt line and shows the vector on a registered output. Software claims the interrupt by reading the acknowledge register. That read returns the vector, saves the old current priority on a small last-in-first-out stack, and raises the current priority to that of the claimed source. A later end-of-interrupt write restores the saved level. A higher-priority source can therefore preempt a handler while a lower one waits.

Top module: `prio_vec_intc`

## Requirements
- R1: After a synchronous reset, the following are all 0: `irq_o`, `vec_o`, `bus_rdata_o`, the current priority, every software request flag and every source priority.
- R2: The priority of source i is a 4-bit read/write register at word address 256+i. Reads return it in bits [3:0] and zeros above.
- R3: A source whose priority is 0 never causes `irq_o` to rise, even while it is pending.
- R4: `irq_o` and `vec_o` are registered. They reflect the pending set, the priorities and the current priority as sampled at the previous clock edge. `vec_o` is the winner's source index (9 bits), and it is 0 when no source qualifies.
- R5: Among qualifying sources, the one with the highest priority wins. On a tie, the lowest source index wins.
- R6: A source qualifies only if its priority is strictly greater than the current priority. The current priority is a read/write register at address 0, in bits [3:0].
- R7: Writing to address 3 sets the software flags whose bits are 1 in wdata[NUM_SW-1:0]. Writing to address 4 clears them. A read of address 3 returns the flags. Software flag k is the pending state of source k. Hardware line j drives source NUM_SW+j.
- R8: A read of address 1 while `irq_o` is high has three effects. It returns `vec_o` in rdata[8:0], pushes the current priority onto the stack, and loads the winner's priority as the current priority. While `irq_o` is low, the same read returns 0x1FF and changes nothing.
- R9: A write to address 2 pops the stack into the current priority. With an empty stack it sets the current priority to 0.
- R10: The stack holds `STACK_DEPTH` (16) entries. A push while it is full is dropped, and the entries already stored are kept.
- R11: Bus reads take effect at a clock edge, and `bus_rdata_o` holds the result from the following cycle until the next read. When write and read strobes arrive together, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_irq_i | input | NUM_SRC-NUM_SW | Level-sensitive hardware requests, line j is source NUM_SW+j |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 9 | Vector of the presented request |

## Verification
The hardest state to reach is a full save stack. Nested claims alone cannot fill it, because each claim strictly raises the current priority and so allows at most fifteen levels of nesting. The stimulus gets around this by claiming a priority-15 software source and then writing a low value back into the current-priority register. It repeats this eighteen times, which overruns the stack. It then unwinds with end-of-interrupt writes past the empty point and checks every restored level. A long randomized phase mixes toggling hardware lines, priority rewrites, claims and pops against a behavioural model that is compared on every cycle.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int PRIO_W    = 4;
  localparam int VEC_W     = 9;
  localparam int PRIO_BASE = 256;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [VEC_W-1:0]  vec_t;

  localparam vec_t VEC_NONE = '1;

  localparam int ADR_CPR   = 0;
  localparam int ADR_ACK   = 1;
  localparam int ADR_EOI   = 2;
  localparam int ADR_SWSET = 3;
  localparam int ADR_SWCLR = 4;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CPR, SEL_ACK, SEL_EOI, SEL_SWSET, SEL_SWCLR, SEL_PRIO
  } reg_sel_e;
endpackage

// File: rtl/pvic_arb.sv
module pvic_arb
  import pvic_pkg::*;
#(
  parameter int NUM_SRC = 155
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  prio_t              prio_i [NUM_SRC],
  input  prio_t              cpr_i,
  output logic               valid_o,
  output vec_t               vec_o,
  output prio_t              prio_o
);
  localparam int LVLS   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 0;
  localparam int LEAVES = 1 << LVLS;
  localparam int NODES  = 2 * LEAVES;

  // Heap-ordered tournament tree: node n has children 2n and 2n+1,
  // leaves sit at LEAVES+i. The left child always holds lower indices,
  // so a tie keeps the left one.
  always_comb begin
    logic  nv [NODES];
    prio_t np [NODES];
    vec_t  ni [NODES];
    logic  take_r;
    nv[0] = 1'b0;
    np[0] = '0;
    ni[0] = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      nv[LEAVES+i] = pend_i[i] && (prio_i[i] > cpr_i);
      np[LEAVES+i] = prio_i[i];
      ni[LEAVES+i] = VEC_W'(i);
    end
    for (int i = NUM_SRC; i < LEAVES; i++) begin
      nv[LEAVES+i] = 1'b0;
      np[LEAVES+i] = '0;
      ni[LEAVES+i] = '0;
    end
    for (int n = LEAVES - 1; n >= 1; n--) begin
      take_r = nv[2*n+1] && (!nv[2*n] || (np[2*n+1] > np[2*n]));
      nv[n]  = nv[2*n] || nv[2*n+1];
      np[n]  = take_r ? np[2*n+1] : np[2*n];
      ni[n]  = take_r ? ni[2*n+1] : ni[2*n];
    end
    valid_o = nv[1];
    vec_o   = nv[1] ? ni[1] : '0;
    prio_o  = nv[1] ? np[1] : '0;
  end
endmodule

// File: rtl/pvic_prio_file.sv
module pvic_prio_file
  import pvic_pkg::*;
#(
  parameter int NUM_SRC = 155,
  parameter int IDX_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  prio_t            wdata_i,
  output prio_t            rdata_o,
  output prio_t            prio_o [NUM_SRC]
);
  prio_t prio_q [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : gen_prio
    always_ff @(posedge clk) begin
      if (rst) begin
        prio_q[g] <= '0;
      end else if (wr_en_i && (idx_i == IDX_W'(g))) begin
        prio_q[g] <= wdata_i;
      end
    end
    assign prio_o[g] = prio_q[g];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (idx_i == IDX_W'(i)) rdata_o = prio_q[i];
    end
  end
endmodule

// File: rtl/pvic_lifo.sv
module pvic_lifo #(
  parameter int DEPTH = 16,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign dout_o  = empty_o ? '0 : mem[PTR_W'(cnt_q - 1'b1)];

  always_ff @(posedge clk) begin
    if (push_i && !full_o) mem[PTR_W'(cnt_q)] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (push_i && !full_o) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R10: a push into a full stack is dropped
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (push_i && full_o) |=> (cnt_q == $past(cnt_q)));
  // R10: an accepted push is visible on the top of the stack
  assert_push_top_R10: assert property (@(posedge clk) disable iff (rst)
    (push_i && !full_o) |=> (dout_o == $past(din_i)));
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import pvic_pkg::*;
#(
  parameter int NUM_SRC     = 155,
  parameter int NUM_SW      = 8,
  parameter int STACK_DEPTH = 16,
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-NUM_SW-1:0] hw_irq_i,
  input  logic                      bus_we_i,
  input  logic                      bus_re_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic [DATA_W-1:0]         bus_wdata_i,
  output logic [DATA_W-1:0]         bus_rdata_o,
  output logic                      irq_o,
  output logic [8:0]                vec_o
);
  logic [NUM_SW-1:0]  sw_q;
  prio_t              cpr_q;
  logic               irq_q;
  vec_t               vec_q;
  prio_t              vpri_q;
  logic [DATA_W-1:0]  rdata_q;

  logic [NUM_SRC-1:0] pend;
  prio_t              prio_all [NUM_SRC];
  prio_t              prio_rd;
  logic               win_valid;
  vec_t               win_vec;
  prio_t              win_prio;

  reg_sel_e           sel;
  logic               do_wr, do_rd, prio_hit;
  logic [ADDR_W-1:0]  pidx;
  logic               lifo_push, lifo_pop, lifo_empty, lifo_full;
  prio_t              lifo_top;
  logic [DATA_W-1:0]  rd_val;
  logic               unused_wdata;

  assign pend = {hw_irq_i, sw_q};
  assign unused_wdata = ^bus_wdata_i;

  // register decode
  assign do_wr    = bus_we_i;
  assign do_rd    = bus_re_i && !bus_we_i;
  assign pidx     = bus_addr_i - ADDR_W'(PRIO_BASE);
  assign prio_hit = (bus_addr_i >= ADDR_W'(PRIO_BASE)) &&
                    (pidx < ADDR_W'(NUM_SRC));

  always_comb begin
    sel = SEL_NONE;
    if (prio_hit)                             sel = SEL_PRIO;
    else if (bus_addr_i == ADDR_W'(ADR_CPR))   sel = SEL_CPR;
    else if (bus_addr_i == ADDR_W'(ADR_ACK))   sel = SEL_ACK;
    else if (bus_addr_i == ADDR_W'(ADR_EOI))   sel = SEL_EOI;
    else if (bus_addr_i == ADDR_W'(ADR_SWSET)) sel = SEL_SWSET;
    else if (bus_addr_i == ADDR_W'(ADR_SWCLR)) sel = SEL_SWCLR;
  end

  pvic_prio_file #(.NUM_SRC(NUM_SRC), .IDX_W(ADDR_W)) u_prio (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (do_wr && (sel == SEL_PRIO)),
    .idx_i   (pidx),
    .wdata_i (bus_wdata_i[PRIO_W-1:0]),
    .rdata_o (prio_rd),
    .prio_o  (prio_all)
  );

  pvic_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend_i  (pend),
    .prio_i  (prio_all),
    .cpr_i   (cpr_q),
    .valid_o (win_valid),
    .vec_o   (win_vec),
    .prio_o  (win_prio)
  );

  assign lifo_push = do_rd && (sel == SEL_ACK) && irq_q;
  assign lifo_pop  = do_wr && (sel == SEL_EOI);

  pvic_lifo #(.DEPTH(STACK_DEPTH), .W(PRIO_W)) u_lifo (
    .clk     (clk),
    .rst     (rst),
    .push_i  (lifo_push),
    .pop_i   (lifo_pop),
    .din_i   (cpr_q),
    .dout_o  (lifo_top),
    .empty_o (lifo_empty),
    .full_o  (lifo_full)
  );

  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_CPR:   rd_val[PRIO_W-1:0] = cpr_q;
      SEL_ACK:   rd_val[VEC_W-1:0]  = irq_q ? vec_q : VEC_NONE;
      SEL_SWSET: rd_val[NUM_SW-1:0] = sw_q;
      SEL_PRIO:  rd_val[PRIO_W-1:0] = prio_rd;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpr_q   <= '0;
      sw_q    <= '0;
      irq_q   <= 1'b0;
      vec_q   <= '0;
      vpri_q  <= '0;
      rdata_q <= '0;
    end else begin
      irq_q  <= win_valid;
      vec_q  <= win_vec;
      vpri_q <= win_prio;
      if (do_wr) begin
        case (sel)
          SEL_CPR:   cpr_q <= bus_wdata_i[PRIO_W-1:0];
          SEL_EOI:   cpr_q <= lifo_empty ? '0 : lifo_top;
          SEL_SWSET: sw_q  <= sw_q | bus_wdata_i[NUM_SW-1:0];
          SEL_SWCLR: sw_q  <= sw_q & ~bus_wdata_i[NUM_SW-1:0];
          default: ;
        endcase
      end else if (do_rd) begin
        rdata_q <= rd_val;
        if (lifo_push) cpr_q <= vpri_q;
      end
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;
  assign vec_o       = vec_q;

  // R3: a presented request never carries priority 0
  assert_prio_zero_silent_R3: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (vpri_q != '0));
  // R6: the presented winner was strictly above the level in force
  assert_above_level_R6: assert property (@(posedge clk) disable iff (rst)
    win_valid |=> (irq_q && (vpri_q > $past(cpr_q))));
  // R8: a claim raises the current level to the claimed priority
  assert_ack_raises_R8: assert property (@(posedge clk) disable iff (rst)
    lifo_push |=> (cpr_q == $past(vpri_q)));
  // R9: an end-of-interrupt on an empty stack returns to level 0
  assert_eoi_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (lifo_pop && lifo_empty) |=> (cpr_q == '0));
  // R7: cleared software flags are low afterwards
  assert_sw_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (do_wr && sel == SEL_SWCLR) |=> ((sw_q & $past(bus_wdata_i[NUM_SW-1:0])) == '0));
endmodule

// File: tb/prio_vec_intc_tb_top.sv
module prio_vec_intc_tb_top;
  localparam int NSRC = 155;
  localparam int NSW  = 8;
  localparam int NHW  = NSRC - NSW;
  localparam int SDEP = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NHW-1:0]  hw = '0;
  logic            we = 1'b0;
  logic            re = 1'b0;
  logic [9:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            irq;
  logic [8:0]      vec;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_vec_intc dut_i (
    .clk(clk), .rst(rst), .hw_irq_i(hw), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .vec_o(vec)
  );

  // behavioural reference model
  int m_cpr, m_sw, m_vec, m_vpri, m_rdata;
  bit m_irq;
  int m_prio [NSRC];
  int m_stack [$];

  always @(posedge clk) begin : model
    int bv, bp, rd;
    bit pnd;
    if (rst) begin
      m_cpr = 0; m_sw = 0; m_vec = 0; m_vpri = 0; m_rdata = 0; m_irq = 0;
      for (int i = 0; i < NSRC; i++) m_prio[i] = 0;
      m_stack.delete();
    end else begin
      bv = -1; bp = 0;
      for (int i = 0; i < NSRC; i++) begin
        pnd = (i < NSW) ? m_sw[i] : hw[i-NSW];
        if (pnd && m_prio[i] > m_cpr && (bv < 0 || m_prio[i] > bp)) begin
          bv = i; bp = m_prio[i];
        end
      end
      if (we) begin
        if (addr == 0) m_cpr = wdata & 15;
        else if (addr == 2) m_cpr = (m_stack.size() > 0) ? m_stack.pop_back() : 0;
        else if (addr == 3) m_sw = m_sw | (wdata & 255);
        else if (addr == 4) m_sw = m_sw & ~(wdata & 255);
        else if (addr >= 256 && addr < 256 + NSRC) m_prio[addr-256] = wdata & 15;
      end else if (re) begin
        rd = 0;
        if (addr == 0) rd = m_cpr;
        else if (addr == 1) begin
          if (m_irq) begin
            rd = m_vec;
            if (m_stack.size() < SDEP) m_stack.push_back(m_cpr);
            m_cpr = m_vpri;
          end else rd = 511;
        end
        else if (addr == 3) rd = m_sw;
        else if (addr >= 256 && addr < 256 + NSRC) rd = m_prio[addr-256];
        m_rdata = rd;
      end
      m_irq = (bv >= 0);
      m_vec = (bv < 0) ? 0 : bv;
      m_vpri = (bv < 0) ? 0 : bp;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model (R4, R5, R11)
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R4 irq", int'(irq), int'(m_irq));
      check("R5 vec", int'(vec), m_vec);
      check("R11 rdata", int'(rdata), m_rdata);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    we = 1'b1; addr = 10'(a); wdata = 32'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdr(int a, output int d);
    @(negedge clk);
    re = 1'b1; addr = 10'(a);
    @(negedge clk);
    re = 1'b0;
    d = int'(rdata);
  endtask

  initial begin
    int v;
    int expq [$];
    idle(3);
    rst = 1'b0;
    idle(2);
    check("R1 irq", int'(irq), 0);
    check("R1 vec", int'(vec), 0);
    check("R1 rdata", int'(rdata), 0);
    rdr(0, v);  check("R1 cpr", v, 0);
    rdr(276, v); check("R1 prio", v, 0);
    rdr(3, v);  check("R1 sw", v, 0);

    // priority 0 source stays silent
    hw[42] = 1'b1;
    idle(3);
    check("R3 irq", int'(irq), 0);

    wr(256 + 20, 5);
    rdr(256 + 20, v); check("R2 readback", v, 5);
    wr(256 + 20, 32'hFFF5);
    rdr(256 + 20, v); check("R2 width", v, 5);
    hw[12] = 1'b1;
    idle(2);
    check("R4 irq", int'(irq), 1);
    check("R4 vec", int'(vec), 20);

    wr(256 + 30, 5); hw[22] = 1'b1; idle(2);
    check("R5 tie", int'(vec), 20);
    wr(256 + 40, 9); hw[32] = 1'b1; idle(2);
    check("R5 highest", int'(vec), 40);

    rdr(1, v); check("R8 ack vec", v, 40);
    rdr(0, v); check("R8 cpr loaded", v, 9);
    idle(2);
    check("R6 masked below", int'(irq), 0);
    wr(256 + 60, 9); hw[52] = 1'b1; idle(2);
    check("R6 masked equal", int'(irq), 0);
    wr(256 + 60, 12); idle(2);
    check("R6 preempt", int'(vec), 60);
    rdr(1, v); check("R8 nested ack", v, 60);
    rdr(0, v); check("R8 nested cpr", v, 12);
    wr(2, 0); rdr(0, v); check("R9 pop1", v, 9);
    wr(2, 0); rdr(0, v); check("R9 pop2", v, 0);
    wr(2, 0); rdr(0, v); check("R9 pop empty", v, 0);

    wr(0, 15); idle(2);
    check("R6 cpr15", int'(irq), 0);
    rdr(1, v); check("R8 spurious", v, 511);
    rdr(0, v); check("R8 no change", v, 15);

    hw = '0;
    wr(0, 0);
    wr(256 + 3, 7);
    wr(3, 8);
    rdr(3, v); check("R7 set", v, 8);
    idle(1);
    check("R7 sw vec", int'(vec), 3);
    wr(4, 8);
    rdr(3, v); check("R7 clear", v, 0);
    idle(2);
    check("R7 irq off", int'(irq), 0);

    // fill and overrun the save stack
    wr(256 + 3, 15);
    wr(3, 8);
    for (int k = 0; k < 18; k++) begin
      int cur;
      rdr(0, cur);
      idle(2);
      rdr(1, v); check("R10 ack", v, 3);
      if (expq.size() < SDEP) expq.push_back(cur);
      wr(0, k % 14);
    end
    wr(4, 8);
    for (int k = 0; k < 18; k++) begin
      int e;
      e = (expq.size() > 0) ? expq.pop_back() : 0;
      wr(2, 0);
      rdr(0, v); check("R10 pop", v, e);
    end

    // randomized phase, compared against the model every cycle
    for (int c = 0; c < 2500; c++) begin
      int op;
      op = int'($urandom % 10);
      hw[$urandom % NHW] = 1'($urandom % 2);
      case (op)
        0, 1: wr(256 + int'($urandom % NSRC), int'($urandom % 16));
        2, 3: rdr(1, v);
        4:    wr(2, 0);
        5:    wr(3, int'($urandom % 256));
        6:    wr(4, int'($urandom % 256));
        7:    wr(0, int'($urandom % 16));
        8:    rdr(256 + int'($urandom % NSRC), v);
        default: idle(1);
      endcase
    end
    idle(3);
    finish_run();
  end
endmodule